// File: doc/BRIEF.md
# EEPROM Page Latch and Program-Cycle Controller

This block sits behind a two-wire serial slave and handles the storage side of a byte-addressed EEPROM. The serial front end decodes the bus and passes simple one-cycle strobes to it. These strobes load the word address, deliver a received data byte, mark a STOP, or ask for the next read byte. The block holds a 64-byte page latch with a per-byte valid mask, the word address pointer and a behavioural model of the memory array. Locations that have never been programmed read as 0xFF.

Data bytes collected during a write transaction go into the latch at the offset given by the low six pointer bits. A page overrun therefore wraps inside the page. On STOP, every latched byte is written into the array at once, in the page selected by the upper pointer bits. A busy flag is then held for a programmable number of system clocks to stand for the nonvolatile write time. While busy is high, the block ignores every strobe, so the front end can refuse the bus. The write-protect input blocks every array change. The default array is 2048 bytes; setting `ADDR_W` to 15 gives the full 32768-byte array.

Top module: `eep_page_prog`

## Requirements
- R1: After reset, `busy` is 0, `rd_byte` is 0x00 and the page latch holds no valid bytes.
- R2: A taken `wr_strobe` stores `wr_byte` in the latch at offset pointer[5:0] and marks that offset valid. It then increments pointer[5:0] by one and leaves pointer[ADDR_W-1:6] unchanged.
- R3: When more than 64 bytes arrive before STOP, the offset wraps from 63 to 0. A later byte replaces the earlier byte at the same offset, and only the last value reaches the array.
- R4: A taken `stop_commit` with at least one valid byte and `wr_protect` low writes all valid bytes to the array in the same clock. Each goes to address {pointer[ADDR_W-1:6], offset}. `busy` is high from the next cycle on.
- R5: `busy` stays high for exactly `PROG_CYCLES` consecutive clock cycles per program cycle.
- R6: Array bytes at offsets that were not written since the last address load or STOP keep their values after a commit.
- R7: A STOP with no valid bytes, such as a dummy write before a read, leaves the array and the pointer unchanged and does not raise `busy`.
- R8: A STOP taken while `wr_protect` is 1 changes no array byte, does not raise `busy` and discards the latch.
- R9: A taken `rd_req` returns the array byte at the pointer on `rd_byte` one cycle later. It increments the whole ADDR_W-bit pointer, which rolls over from the last address to 0.
- R10: While `busy` is 1, `addr_load`, `wr_strobe`, `rd_req` and `stop_commit` are ignored. The pointer, the latch and the array do not change.
- R11: A taken `addr_load` sets the pointer to `load_addr` and empties the latch. When strobes coincide, `stop_commit` wins over `addr_load`, which wins over `wr_strobe`, which wins over `rd_req`. The losing strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load the word address pointer |
| load_addr | input | ADDR_W | Word address to load |
| wr_strobe | input | 1 | One received data byte |
| wr_byte | input | 8 | Data byte for the latch |
| stop_commit | input | 1 | STOP seen; commit the latch |
| wr_protect | input | 1 | 1 blocks every array change |
| rd_req | input | 1 | Fetch the byte at the pointer and advance |
| rd_byte | output | 8 | Read data, valid the cycle after a taken `rd_req` |
| busy | output | 1 | Program cycle in progress; all strobes ignored |

## Verification
The page write is driven with a short two-byte write, a write that starts two bytes before a page edge and crosses it, and a 65-byte burst. The first tells a correct commit from a partial one. The second separates in-page wrapping from a carry into the next page. The third shows whether the last byte or the first byte wins at a reused offset. Each is followed by reads of the written bytes and of untouched neighbours, so an unmasked commit shows up. Dummy, protected and busy-time strobes are each followed by a read of the address they could have changed. A read at the top address shows whether the pointer rolls over to zero.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int BYTE_W    = 8;
  localparam int PAGE_W_DF = 6;

  // Strobes after arbitration; at most one of the take flags is set.
  typedef struct packed {
    logic stop_take;
    logic commit_go;
    logic load_take;
    logic wr_take;
    logic rd_take;
  } eep_evt_t;

  // Priority: stop > load > write > read, and nothing while busy.
  function automatic eep_evt_t eep_arbitrate(input logic busy, input logic stop,
                                             input logic any_valid, input logic wp,
                                             input logic load, input logic wr,
                                             input logic rd);
    eep_evt_t e;
    e.stop_take = !busy && stop;
    e.commit_go = e.stop_take && any_valid && !wp;
    e.load_take = !busy && !stop && load;
    e.wr_take   = !busy && !stop && !load && wr;
    e.rd_take   = !busy && !stop && !load && !wr && rd;
    return e;
  endfunction

endpackage

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step_page,
  input  logic              step_full,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - PAGE_W;

  // Write stepping: offset wraps inside the page, page bits fixed.
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] off;
    off = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], off};
  endfunction

  // Read stepping: whole pointer, rolls to zero at the top.
  function automatic logic [ADDR_W-1:0] full_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (load)      ptr <= load_addr;
    else if (step_page) ptr <= page_step(ptr);
    else if (step_full) ptr <= full_step(ptr);
  end

  // R2
  page_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R9
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_full && !load && !step_page) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = ptr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic                              wr_en,
  input  logic [PAGE_W-1:0]                 wr_off,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] page_q,
  output logic [(1<<PAGE_W)-1:0]            valid_q
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      valid_q <= '0;
    end else if (clear) begin
      valid_q <= '0;
    end else if (wr_en) begin
      page_q[wr_off]  <= wr_data;
      valid_q[wr_off] <= 1'b1;
    end
  end

  // R2
  slot_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> valid_q[$past(wr_off)]);

  // R11
  latch_emptied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_q == '0));

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) latch_reset_chk: assert ($countones(valid_q) == 0 && PAGE_BYTES > 0);
  end
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam int RUN_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  // Checker-side count of busy cycles already elapsed in this run.
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + RUN_W'(1);
    else           run_len <= '0;
  end

  // R5
  busy_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < RUN_W'(PROG_CYCLES)));

  // R5
  busy_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run_len) == RUN_W'(PROG_CYCLES - 1)));
endmodule

// File: rtl/eep_page_prog.sv
module eep_page_prog
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = PAGE_W_DF,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_strobe,
  input  logic [7:0]        wr_byte,
  input  logic              stop_commit,
  input  logic              wr_protect,
  input  logic              rd_req,
  output logic [7:0]        rd_byte,
  output logic              busy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0]                   ptr;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0]   page_q;
  logic [PAGE_BYTES-1:0]               valid_q;
  logic                                any_valid;
  logic [HI_W-1:0]                     page_hi;
  eep_evt_t                            evt;

  // Named internal events for the assertions.
  logic stop_take, commit_go, load_take, wr_take, rd_take, latch_clear;

  assign any_valid = |valid_q;
  assign page_hi   = ptr[ADDR_W-1:PAGE_W];
  assign evt       = eep_arbitrate(busy, stop_commit, any_valid, wr_protect,
                                   addr_load, wr_strobe, rd_req);
  assign stop_take   = evt.stop_take;
  assign commit_go   = evt.commit_go;
  assign load_take   = evt.load_take;
  assign wr_take     = evt.wr_take;
  assign rd_take     = evt.rd_take;
  assign latch_clear = stop_take || load_take;

  eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_take),
    .load_addr (load_addr),
    .step_page (wr_take),
    .step_full (rd_take),
    .ptr       (ptr)
  );

  eep_page_latch #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (latch_clear),
    .wr_en   (wr_take),
    .wr_off  (ptr[PAGE_W-1:0]),
    .wr_data (wr_byte),
    .page_q  (page_q),
    .valid_q (valid_q)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .busy  (busy)
  );

  // Array model; unprogrammed cells read as erased.
  logic [BYTE_W-1:0] cells [DEPTH];
  initial begin
    for (int a = 0; a < DEPTH; a++) cells[a] = 8'hFF;
  end

  // Whole-page commit in one clock, masked per byte.
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit_go && valid_q[i])
        cells[{page_hi, PAGE_W'(i)}] <= page_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_byte <= '0;
    else if (rd_take) rd_byte <= cells[ptr];
  end

  // R4
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  // R7
  empty_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_take && !any_valid) |=> (!busy && $stable(ptr)));

  // R8
  protect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_take && wr_protect) |=> !busy);

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ptr) && $stable(valid_q) && $stable(rd_byte)));

  // R11
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_take, load_take, wr_take, rd_take}));
endmodule

// File: tb/test_eep_page_prog.sv
module test_eep_page_prog;
  localparam int AW   = 11;
  localparam int PROG = 20;

  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_SP = 2'd2;
  localparam logic [1:0] OP_RD = 2'd3;

  // op, protect, address or data, expected (read byte, or busy for a STOP)
  typedef struct packed {
    logic [1:0]  op;
    logic        wp;
    logic [10:0] arg;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{OP_LD, 1'b0, 11'h040, 8'h00},
    '{OP_WR, 1'b0, 11'h0AA, 8'h00},
    '{OP_WR, 1'b0, 11'h0BB, 8'h00},
    '{OP_SP, 1'b0, 11'h000, 8'h01},   // R4 busy rises
    '{OP_LD, 1'b0, 11'h000, 8'h00},
    '{OP_WR, 1'b0, 11'h05A, 8'h00},
    '{OP_SP, 1'b0, 11'h000, 8'h01},   // R4
    '{OP_LD, 1'b0, 11'h040, 8'h00},
    '{OP_RD, 1'b0, 11'h000, 8'hAA},   // R4
    '{OP_RD, 1'b0, 11'h000, 8'hBB},   // R2
    '{OP_RD, 1'b0, 11'h000, 8'hFF},   // R6 unwritten offset
    '{OP_LD, 1'b0, 11'h07E, 8'h00},
    '{OP_WR, 1'b0, 11'h011, 8'h00},
    '{OP_WR, 1'b0, 11'h012, 8'h00},
    '{OP_WR, 1'b0, 11'h013, 8'h00},
    '{OP_SP, 1'b0, 11'h000, 8'h01},
    '{OP_LD, 1'b0, 11'h07E, 8'h00},
    '{OP_RD, 1'b0, 11'h000, 8'h11},
    '{OP_RD, 1'b0, 11'h000, 8'h12},
    '{OP_RD, 1'b0, 11'h000, 8'hFF},   // R2 next page untouched
    '{OP_LD, 1'b0, 11'h040, 8'h00},
    '{OP_RD, 1'b0, 11'h000, 8'h13},   // R2 wrapped to offset 0
    '{OP_RD, 1'b0, 11'h000, 8'hBB},   // R6
    '{OP_LD, 1'b0, 11'h7FF, 8'h00},
    '{OP_SP, 1'b0, 11'h000, 8'h00},   // R7 dummy write
    '{OP_RD, 1'b0, 11'h000, 8'hFF},   // R7 pointer kept
    '{OP_RD, 1'b0, 11'h000, 8'h5A},   // R9 rollover
    '{OP_LD, 1'b0, 11'h040, 8'h00},
    '{OP_WR, 1'b0, 11'h099, 8'h00},
    '{OP_SP, 1'b1, 11'h000, 8'h00},   // R8 protected
    '{OP_LD, 1'b0, 11'h040, 8'h00},
    '{OP_RD, 1'b0, 11'h000, 8'h13},   // R8 array unchanged
    '{OP_SP, 1'b0, 11'h000, 8'h00},   // R8 latch discarded
    '{OP_LD, 1'b0, 11'h041, 8'h00},
    '{OP_RD, 1'b0, 11'h000, 8'hBB}    // R11 load sets pointer
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic          wr_strobe = 1'b0;
  logic [7:0]    wr_byte = '0;
  logic          stop_commit = 1'b0;
  logic          wr_protect = 1'b0;
  logic          rd_req = 1'b0;
  logic [7:0]    rd_byte;
  logic          busy;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  eep_page_prog #(.ADDR_W(AW), .PROG_CYCLES(PROG)) i_eep_page_prog (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_load   (addr_load),
    .load_addr   (load_addr),
    .wr_strobe   (wr_strobe),
    .wr_byte     (wr_byte),
    .stop_commit (stop_commit),
    .wr_protect  (wr_protect),
    .rd_req      (rd_req),
    .rd_byte     (rd_byte),
    .busy        (busy)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    addr_load = 1'b1; load_addr = a;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_strobe = 1'b1; wr_byte = d;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic do_stop(input logic wp);
    stop_commit = 1'b1; wr_protect = wp;
    @(negedge clk);
    stop_commit = 1'b0; wr_protect = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(req, int'(rd_byte), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 rd_byte", int'(rd_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      wait_idle();
      case (VEC[k].op)
        OP_LD: do_load(VEC[k].arg);
        OP_WR: do_write(VEC[k].arg[7:0]);
        OP_SP: begin
          do_stop(VEC[k].wp);
          check("R4/R7/R8 busy after STOP", int'(busy), int'(VEC[k].exp[0]));
        end
        default: do_read("R2/R3/R6/R9 read", VEC[k].exp);
      endcase
    end

    // R3 65-byte burst: byte 64 lands on offset 0
    wait_idle();
    do_load(11'h100);
    for (int i = 0; i < 65; i++) do_write(8'(i));
    do_stop(1'b0);
    wait_idle();
    do_load(11'h100);
    do_read("R3 offset0 overwritten", 8'h40);
    do_read("R3 offset1 kept", 8'h01);
    do_load(11'h13F);
    do_read("R3 last offset", 8'h3F);

    // R5 busy length and R10 strobes ignored while busy
    begin
      int n;
      do_load(11'h200);
      do_write(8'h77);
      do_stop(1'b0);
      n = 0;
      while (busy) begin
        n++;
        if (n <= 3) begin
          addr_load = 1'b1; load_addr = 11'h000;
          wr_strobe = 1'b1; wr_byte = 8'h55;
          rd_req = 1'b1;
        end else begin
          addr_load = 1'b0; wr_strobe = 1'b0; rd_req = 1'b0;
        end
        @(negedge clk);
      end
      addr_load = 1'b0; wr_strobe = 1'b0; rd_req = 1'b0;
      check("R5 busy cycles", n, PROG);
    end
    do_read("R10 pointer not moved while busy", 8'hFF);
    do_load(11'h200);
    do_read("R10 committed byte", 8'h77);
    do_read("R10 busy write dropped", 8'hFF);
    do_load(11'h000);
    do_read("R10 address 0 intact", 8'h5A);

    // R11 priority: load wins over a same-cycle write
    addr_load = 1'b1; load_addr = 11'h041; wr_strobe = 1'b1; wr_byte = 8'hEE;
    @(negedge clk);
    addr_load = 1'b0; wr_strobe = 1'b0;
    do_stop(1'b0);
    check("R11 write lost to load", int'(busy), 0);
    do_read("R11 load applied", 8'hBB);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule